// File: doc/BRIEF.md
# Cycle Counter with Control Register

This block counts core clock cycles in a 32-bit register and is steered by a small control register. Both registers sit on a simple read/write bus with one address each. The control register holds four stored fields: run enable, prescale select, a spare bit, and a bit that stops counting while a prohibition input is high. It also has a write-only clear strobe. The counter advances on every active cycle, or on every 64th active cycle when the prescaler is selected. It freezes whenever counting is not active.

Software starts and stops the counter by writing the control register, and reads the counter to measure elapsed cycles. It can preload the counter or zero it through the clear strobe. When the counter rolls over, a sticky flag is set. That flag appears in the top bit of the control register read value and stays set until the next clear.

Top module: `cyc_count_unit`

## Requirements
- R1: After reset, the counter reads 0 and the control register reads 0.
- R2: While control bit 0 (enable) is 1, bit 3 is 0 and counting is not prohibited, the counter rises by one on every clock edge. A control write takes effect from the edge that follows it.
- R3: While bit 0 is 0, the counter keeps its value and reads return that value unchanged.
- R4: When control bit 5 and the `prohibit` input are both 1, the counter holds. When either of them is 0, counting follows bit 0.
- R5: With bit 3 set, the counter rises once per 64 active cycles. A 6-bit prescaler counts only active cycles and keeps a partial count across stretches where counting is stopped.
- R6: The prescaler returns to zero on a clear, and on any control write that changes the value of bit 3.
- R7: A control write with bit 2 set zeroes the counter and the overflow flag. Bit 2 always reads back as 0. The clear wins over an increment on the same edge.
- R8: A control write stores only bits 0, 3, 4 and 5 (mask 0x39). The control read value has those bits as stored, the overflow flag in bit 31, and 0 in every other bit.
- R9: An increment from 0xFFFFFFFF gives 0 and sets the overflow flag. The flag stays set through later counting and counter loads until a clear or reset.
- R10: A write to the counter address (1) loads the written value. The load wins over an increment on the same edge.
- R11: A read raises `rd_valid` with `rdata` one cycle after `rd_en`. The data is the register value from before that edge. Control is at address 0 and the counter at address 1. Other addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address (0 control, 1 counter) |
| wdata | input | 32 | Write data |
| prohibit | input | 1 | Counting-prohibited condition |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 32 | Read data |

## Verification
Two pairs of functions can meet on one clock edge: a counter load with an enabled increment, and a clear strobe with an increment that would roll the counter over. The bench sets up the first by enabling the counter and writing the counter address on the very next edge, then stops it one edge later. The expected value is therefore the loaded value plus exactly one. It sets up the second by preloading 0xFFFFFFFF, enabling, and clearing on the following edge. It then expects a counter of 0 and a control read with the overflow bit still 0.

// File: rtl/cyc_count_pkg.sv
package cyc_count_pkg;

    localparam int EN_BIT  = 0;
    localparam int CLR_BIT = 2;
    localparam int DIV_BIT = 3;
    localparam int AUX_BIT = 4;
    localparam int DP_BIT  = 5;
    localparam int FIELD_W = 6;

    typedef struct packed {
        logic dp;
        logic aux;
        logic div;
        logic en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(logic [FIELD_W-1:0] w);
        ctrl_t c;
        c.dp  = w[DP_BIT];
        c.aux = w[AUX_BIT];
        c.div = w[DIV_BIT];
        c.en  = w[EN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/cyc_ctrl_reg.sv
module cyc_ctrl_reg
    import cyc_count_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_sel,
    input  ctrl_t wr_fields,
    output ctrl_t ctrl,
    output logic  div_chg
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_sel) begin
            ctrl_d = wr_fields;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl    = ctrl_q;
    assign div_chg = wr_sel && (wr_fields.div != ctrl_q.div);
endmodule

// File: rtl/cyc_prescale.sv
module cyc_prescale #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic div,
    input  logic clear,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clear) begin
            pre_d = '0;
        end else if (active && div) begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end

    assign tick = active && (!div || (pre_q == PRE_LAST));
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             ovf;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_MAX) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/cyc_count_unit.sv
module cyc_count_unit
    import cyc_count_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int CNT_ADDR  = 1,
    parameter int PRE_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prohibit,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_ADDR);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    ctrl_t             ctrl_q;
    logic              ctrl_wr;
    logic              clr_pulse;
    logic              div_chg;
    logic              load;
    logic              active;
    logic              tick;
    logic [DATA_W-1:0] cnt_w;
    logic              ovf_w;
    logic [DATA_W-1:0] ctrl_word;
    rd_st_t            rd_d, rd_q;

    assign ctrl_wr   = wr_en && (addr == A_CTRL);
    assign clr_pulse = ctrl_wr && wdata[CLR_BIT];
    assign load      = wr_en && (addr == A_CNT);
    assign active    = ctrl_q.en && !(ctrl_q.dp && prohibit);

    cyc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_sel    (ctrl_wr),
        .wr_fields (ctrl_from_word(wdata[FIELD_W-1:0])),
        .ctrl      (ctrl_q),
        .div_chg   (div_chg)
    );

    cyc_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .div    (ctrl_q.div),
        .clear  (clr_pulse || div_chg),
        .tick   (tick)
    );

    cyc_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_pulse),
        .load     (load),
        .load_val (wdata),
        .tick     (tick),
        .cnt      (cnt_w),
        .ovf      (ovf_w)
    );

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[EN_BIT]   = ctrl_q.en;
        ctrl_word[DIV_BIT]  = ctrl_q.div;
        ctrl_word[AUX_BIT]  = ctrl_q.aux;
        ctrl_word[DP_BIT]   = ctrl_q.dp;
        ctrl_word[DATA_W-1] = ovf_w;

        rd_d.valid = rd_en;
        rd_d.data  = '0;
        if (rd_en) begin
            if (addr == A_CTRL)     rd_d.data = ctrl_word;
            else if (addr == A_CNT) rd_d.data = cnt_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rdata    = rd_q.data;
endmodule

// File: rtl/cyc_count_chk.sv
module cyc_count_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              prohibit,
    input logic              ctrl_en,
    input logic              ctrl_dp,
    input logic              ctrl_div,
    input logic              clr,
    input logic              load,
    input logic [DATA_W-1:0] load_val,
    input logic [DATA_W-1:0] cnt,
    input logic              ovf
);
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (cnt == '0) && !ovf);

    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !(ctrl_dp && prohibit) && !ctrl_div && !clr && !load)
        |=> cnt == $past(cnt) + 1'b1);

    a_r3_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && !clr && !load) |=> $stable(cnt));

    a_r4_prohibit_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl_dp && prohibit && !clr && !load) |=> $stable(cnt));

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0) && !ovf);

    a_r9_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> cnt == $past(load_val));

    a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
endmodule

bind cyc_count_unit cyc_count_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .prohibit (prohibit),
    .ctrl_en  (ctrl_q.en),
    .ctrl_dp  (ctrl_q.dp),
    .ctrl_div (ctrl_q.div),
    .clr      (clr_pulse),
    .load     (load),
    .load_val (wdata),
    .cnt      (cnt_w),
    .ovf      (ovf_w)
);

// File: tb/cyc_count_unit_tb_top.sv
`timescale 1ns/1ps
module cyc_count_unit_tb_top;
    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_CNT  = 4'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        prohibit = 1'b0;
    logic        rd_valid;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cyc_count_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .prohibit (prohibit),
        .rd_valid (rd_valid),
        .rdata    (rdata)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R11 unexpected rd_valid: actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // Reset state
        rd(A_CTRL, 32'h0, "R1 ctrl after reset");
        rd(A_CNT,  32'h0, "R1 cnt after reset");
        // Count every cycle: 10 active edges
        wr(A_CTRL, 32'h1); idle(9); wr(A_CTRL, 32'h0);
        rd(A_CNT, 32'd10, "R2 count per cycle");
        idle(5);
        rd(A_CNT, 32'd10, "R3 hold while disabled");
        // Clear strobe, reads back 0
        wr(A_CTRL, 32'h4);
        rd(A_CNT,  32'h0, "R7 clear");
        rd(A_CTRL, 32'h0, "R7 clear bit reads 0");
        // Write mask
        wr(A_CTRL, 32'hFFFF_FFC6);
        rd(A_CTRL, 32'h0, "R8 unstored bits ignored");
        wr(A_CTRL, 32'h38);
        rd(A_CTRL, 32'h38, "R8 stored bits");
        wr(A_CTRL, 32'h0);
        // Load
        wr(A_CNT, 32'h1234);
        rd(A_CNT, 32'h1234, "R10 load");
        // Prohibit
        prohibit = 1'b1;
        wr(A_CTRL, 32'h21); idle(20); wr(A_CTRL, 32'h0);
        rd(A_CNT, 32'h1234, "R4 prohibited holds");
        wr(A_CTRL, 32'h01); idle(4); wr(A_CTRL, 32'h0);
        rd(A_CNT, 32'h1239, "R4 prohibit ignored without bit5");
        prohibit = 1'b0;
        wr(A_CTRL, 32'h21); idle(2); wr(A_CTRL, 32'h0);
        rd(A_CNT, 32'h123C, "R4 bit5 without prohibit counts");
        // Divider
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h09); idle(63); wr(A_CTRL, 32'h08);
        rd(A_CNT, 32'd1, "R5 one tick per 64");
        wr(A_CTRL, 32'h09); idle(30); wr(A_CTRL, 32'h08);
        rd(A_CNT, 32'd1, "R5 partial no tick");
        wr(A_CTRL, 32'h09); idle(32); wr(A_CTRL, 32'h08);
        rd(A_CNT, 32'd2, "R5 partial count kept");
        wr(A_CTRL, 32'h09); idle(9); wr(A_CTRL, 32'h08);
        wr(A_CTRL, 32'h00);
        wr(A_CTRL, 32'h09); idle(62); wr(A_CTRL, 32'h08);
        rd(A_CNT, 32'd2, "R6 divider change clears prescaler");
        wr(A_CTRL, 32'h09); wr(A_CTRL, 32'h08);
        rd(A_CNT, 32'd3, "R6 tick at 64th after change");
        // Wrap and overflow
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'h1); idle(2); wr(A_CTRL, 32'h0);
        rd(A_CNT,  32'h1, "R9 wrap");
        rd(A_CTRL, 32'h8000_0000, "R9 overflow flag");
        wr(A_CNT, 32'h5);
        rd(A_CTRL, 32'h8000_0000, "R9 flag sticky over load");
        rd(A_CNT,  32'h5, "R10 load after wrap");
        wr(A_CTRL, 32'h4);
        rd(A_CTRL, 32'h0, "R7 clear drops flag");
        rd(A_CNT,  32'h0, "R7 clear after wrap");
        // Same-edge: load vs increment
        wr(A_CTRL, 32'h1); wr(A_CNT, 32'h100); wr(A_CTRL, 32'h0);
        rd(A_CNT, 32'h101, "R10 load wins over increment");
        // Same-edge: clear vs wrapping increment
        wr(A_CNT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1); wr(A_CTRL, 32'h4);
        rd(A_CNT,  32'h0, "R7 clear wins over wrap");
        rd(A_CTRL, 32'h0, "R7 no overflow on cleared wrap");
        // Unmapped
        rd(4'd2, 32'h0, "R11 unmapped read");
        wr(4'd3, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h0, "R11 unmapped write ctrl");
        rd(A_CNT,  32'h0, "R11 unmapped write cnt");
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R11 missing read data: actual %0d pending expected 0", exp_q.size());
        end
        summary();
    end
endmodule